// File: doc/BRIEF.md
# Timestamp Seconds Extension Unit

A frame timestamp leaves the capture logic in compact form. The first 32-bit word carries a 30-bit nanoseconds count. The two bits above it are the least significant bits of the seconds. The second word carries four more seconds bits in its lowest nibble. Together these give a 6-bit truncated seconds value, which repeats every 64 seconds. This block rebuilds the full seconds count. It takes the upper seconds bits from the live time-of-day counter, sampled in the same cycle as the capture strobe.

The 6-bit field may sit in the upper half of its range while the live clock has already passed into the next 64-second window. In that case the truncated top bit is set and the live seconds bit 5 is clear. The block then treats the stamp as belonging to the previous window and subtracts 64 from the merged result. Arithmetic is modulo 2^SEC_W.

Control is a two-state machine. `ST_IDLE` is the state after reset and the state with no pending result. `ST_EMIT` means a result is being presented.
- T_CAPTURE: `ST_IDLE` → `ST_EMIT` on `cap_valid`.
- T_REPEAT: `ST_EMIT` → `ST_EMIT` on `cap_valid`.
- T_DRAIN: `ST_EMIT` → `ST_IDLE` without `cap_valid`.

`out_valid` is high exactly in `ST_EMIT`. The result registers load only on `cap_valid`.

Top module: `ts_ext_top`

## Requirements
- R1: `out_ns` equals bits [29:0] of `cap_word0` taken in the strobe cycle.
- R2: The truncated seconds value T is {`cap_word1`[3:0], `cap_word0`[31:30]}, with word1 bits as the high part. `out_sec`[5:0] always equals T.
- R3: When T[5] is 0, or live seconds bit 5 is 1, `out_sec` = (live seconds with bits [5:0] cleared) + T.
- R4: When T[5] is 1 and live seconds bit 5 is 0, `out_sec` = (live seconds with bits [5:0] cleared) + T − 64, modulo 2^48. This includes the underflow case, where the result wraps.
- R5: Bits [31:4] of `cap_word1` have no effect on any output.
- R6: `out_valid` is high in the cycle after each cycle with `cap_valid` high, and low otherwise. Back-to-back strobes give back-to-back results.
- R7: Without `cap_valid`, `out_sec` and `out_ns` hold their last values.
- R8: After reset, `out_valid`, `out_sec` and `out_ns` are 0.
- R9: Only the live seconds present in the strobe cycle take part. Later changes of `live_sec` do not alter a held result.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cap_valid | input | 1 | Captured timestamp present this cycle |
| cap_word0 | input | 32 | Nanoseconds [29:0], low seconds [31:30] |
| cap_word1 | input | 32 | High truncated seconds [3:0]; rest ignored |
| live_sec | input | 48 | Seconds of the running time-of-day counter |
| out_valid | output | 1 | Full timestamp valid strobe |
| out_sec | output | 48 | Full seconds |
| out_ns | output | 30 | Nanoseconds |

## Verification
A wrong state bit appears at `out_valid` in the very next cycle, either as a missing strobe or as a strobe without a capture. A mistake in the window selection surfaces on the same strobe. It shows as `out_sec` off by exactly 64, or as a wrong upper part when the live counter sits near its all-ones or all-zero value. Stale or wrongly loaded result registers show as values that change while no strobe arrives.

// File: rtl/ts_ext_pkg.sv
package ts_ext_pkg;

    typedef enum logic [0:0] {
        ST_IDLE = 1'b0,
        ST_EMIT = 1'b1
    } ts_ext_state_e;

endpackage

// File: rtl/ts_ext_unpack.sv
module ts_ext_unpack #(
    parameter int WORD_W = 32,
    parameter int NS_W   = 30,
    parameter int LO_W   = 2,
    parameter int HI_W   = 4
) (
    input  logic [WORD_W-1:0]    word0,
    input  logic [WORD_W-1:0]    word1,
    output logic [NS_W-1:0]      ns,
    output logic [LO_W+HI_W-1:0] trunc_sec
);
    localparam int TW = LO_W + HI_W;

    logic [LO_W-1:0] lo_part;

    always_comb begin
        ns        = word0[NS_W-1:0];
        lo_part   = word0[NS_W+LO_W-1:NS_W];
        // only the low HI_W bits of word1 survive the truncating cast
        trunc_sec = TW'({word1, lo_part});
    end

endmodule

// File: rtl/ts_ext_merge.sv
module ts_ext_merge #(
    parameter int SEC_W = 48,
    parameter int TW    = 6
) (
    input  logic [SEC_W-1:0] live_sec,
    input  logic [TW-1:0]    trunc_sec,
    output logic [SEC_W-1:0] full_sec
);
    localparam logic [SEC_W-1:0] WRAP_V   = SEC_W'(1) << TW;
    localparam logic [SEC_W-1:0] LOW_MASK = WRAP_V - SEC_W'(1);

    logic             window_back;
    logic [SEC_W-1:0] base;

    always_comb begin
        window_back = trunc_sec[TW-1] & ~live_sec[TW-1];
        base        = live_sec & ~LOW_MASK;
        full_sec    = base + SEC_W'(trunc_sec) - (window_back ? WRAP_V : '0);
    end

endmodule

// File: rtl/ts_ext_top.sv
module ts_ext_top
    import ts_ext_pkg::*;
#(
    parameter int WORD_W = 32,
    parameter int NS_W   = 30,
    parameter int LO_W   = 2,
    parameter int HI_W   = 4,
    parameter int SEC_W  = 48
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cap_valid,
    input  logic [WORD_W-1:0] cap_word0,
    input  logic [WORD_W-1:0] cap_word1,
    input  logic [SEC_W-1:0]  live_sec,
    output logic              out_valid,
    output logic [SEC_W-1:0]  out_sec,
    output logic [NS_W-1:0]   out_ns
);
    localparam int TW = LO_W + HI_W;

    ts_ext_state_e    state_q, state_d;
    logic [NS_W-1:0]  ns_w;
    logic [TW-1:0]    trunc_w;
    logic [SEC_W-1:0] full_w;

    ts_ext_unpack #(
        .WORD_W(WORD_W), .NS_W(NS_W), .LO_W(LO_W), .HI_W(HI_W)
    ) unpack_i (
        .word0     (cap_word0),
        .word1     (cap_word1),
        .ns        (ns_w),
        .trunc_sec (trunc_w)
    );

    ts_ext_merge #(
        .SEC_W(SEC_W), .TW(TW)
    ) merge_i (
        .live_sec  (live_sec),
        .trunc_sec (trunc_w),
        .full_sec  (full_w)
    );

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: if (cap_valid) state_d = ST_EMIT;   // T_CAPTURE
            ST_EMIT: if (!cap_valid) state_d = ST_IDLE;  // T_DRAIN / T_REPEAT
            default: state_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            out_sec <= '0;
            out_ns  <= '0;
        end else if (cap_valid) begin
            out_sec <= full_w;
            out_ns  <= ns_w;
        end
    end

    assign out_valid = (state_q == ST_EMIT);

endmodule

// File: rtl/ts_ext_checker.sv
module ts_ext_checker #(
    parameter int WORD_W = 32,
    parameter int NS_W   = 30,
    parameter int LO_W   = 2,
    parameter int HI_W   = 4,
    parameter int SEC_W  = 48
) (
    input logic              clk,
    input logic              rst_n,
    input logic              cap_valid,
    input logic [WORD_W-1:0] cap_word0,
    input logic [WORD_W-1:0] cap_word1,
    input logic [SEC_W-1:0]  live_sec,
    input logic              out_valid,
    input logic [SEC_W-1:0]  out_sec,
    input logic [NS_W-1:0]   out_ns
);
    localparam int TW = LO_W + HI_W;

    AST_VALID_AFTER_CAP: assert property (@(posedge clk) disable iff (!rst_n)
        cap_valid |=> out_valid); // R6
    AST_NO_SPURIOUS_VALID: assert property (@(posedge clk) disable iff (!rst_n)
        !cap_valid |=> !out_valid); // R6
    AST_HOLD_RESULT: assert property (@(posedge clk) disable iff (!rst_n)
        !cap_valid |=> ($stable(out_sec) && $stable(out_ns))); // R7
    AST_NS_PASS: assert property (@(posedge clk) disable iff (!rst_n)
        cap_valid |=> out_ns == $past(cap_word0[NS_W-1:0])); // R1
    AST_LOW_SEC: assert property (@(posedge clk) disable iff (!rst_n)
        cap_valid |=> out_sec[TW-1:0] ==
            $past({cap_word1[HI_W-1:0], cap_word0[NS_W+LO_W-1:NS_W]})); // R2
    AST_UPPER_SAME_WINDOW: assert property (@(posedge clk) disable iff (!rst_n)
        (cap_valid && !(cap_word1[HI_W-1] && !live_sec[TW-1])) |=>
            out_sec[SEC_W-1:TW] == $past(live_sec[SEC_W-1:TW])); // R3
    AST_UPPER_PREV_WINDOW: assert property (@(posedge clk) disable iff (!rst_n)
        (cap_valid && cap_word1[HI_W-1] && !live_sec[TW-1]) |=>
            out_sec[SEC_W-1:TW] == $past(live_sec[SEC_W-1:TW]) - 1'b1); // R4

endmodule

bind ts_ext_top ts_ext_checker #(
    .WORD_W(WORD_W), .NS_W(NS_W), .LO_W(LO_W), .HI_W(HI_W), .SEC_W(SEC_W)
) chk_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .cap_valid (cap_valid),
    .cap_word0 (cap_word0),
    .cap_word1 (cap_word1),
    .live_sec  (live_sec),
    .out_valid (out_valid),
    .out_sec   (out_sec),
    .out_ns    (out_ns)
);

// File: tb/ts_ext_tb.sv
module ts_ext_top_tb_top;

    localparam int NV = 7;
    // columns: word0, word1, live seconds, expected seconds, expected ns
    localparam logic [31:0] V_W0 [NV] = '{
        32'h5234_5678, 32'hBB9A_C9FF, 32'h4000_0000, 32'h4000_0001,
        32'hC000_0ABC, 32'h0000_0010, 32'hFFFF_FFFF};
    localparam logic [31:0] V_W1 [NV] = '{
        32'h0000_0003, 32'h0000_000F, 32'h0000_0008, 32'h0000_0000,
        32'hFFFF_FFF5, 32'h0000_0008, 32'h0000_000F};
    localparam logic [47:0] V_LIVE [NV] = '{
        48'h1000, 48'h2001, 48'h2025, 48'h3FFF,
        48'hABCD_0000_0000, 48'h1F, 48'hFFFF_FFFF_FFFF};
    localparam logic [47:0] V_SEC [NV] = '{
        48'h100D, 48'h1FFE, 48'h2021, 48'h3FC1,
        48'hABCD_0000_0017, 48'hFFFF_FFFF_FFE0, 48'hFFFF_FFFF_FFFF};
    localparam logic [29:0] V_NS [NV] = '{
        30'h1234_5678, 30'h3B9A_C9FF, 30'h0, 30'h1,
        30'hABC, 30'h10, 30'h3FFF_FFFF};
    // requirement exercised by each row: R3 R4 R3 R3 R5 R4 R3

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cap_valid = 1'b0;
    logic [31:0] cap_word0 = '0;
    logic [31:0] cap_word1 = '0;
    logic [47:0] live_sec = '0;
    logic        out_valid;
    logic [47:0] out_sec;
    logic [29:0] out_ns;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    always #5 clk = ~clk;

    ts_ext_top dut_i (
        .clk(clk), .rst_n(rst_n), .cap_valid(cap_valid),
        .cap_word0(cap_word0), .cap_word1(cap_word1), .live_sec(live_sec),
        .out_valid(out_valid), .out_sec(out_sec), .out_ns(out_ns)
    );

    task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic capture(input logic [31:0] w0, input logic [31:0] w1, input logic [47:0] lv);
        cap_word0 = w0; cap_word1 = w1; live_sec = lv; cap_valid = 1'b1;
        @(negedge clk);
        cap_valid = 1'b0;
    endtask

    initial begin
        repeat (3) @(negedge clk);
        chk("R8 valid", 64'(out_valid), 64'd0);
        chk("R8 sec", 64'(out_sec), 64'd0);
        chk("R8 ns", 64'(out_ns), 64'd0);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R6 idle", 64'(out_valid), 64'd0);

        for (int i = 0; i < NV; i++) begin
            capture(V_W0[i], V_W1[i], V_LIVE[i]);
            chk("R6 strobe", 64'(out_valid), 64'd1);
            chk("R3/R4/R5 sec", 64'(out_sec), 64'(V_SEC[i]));
            chk("R1 ns", 64'(out_ns), 64'(V_NS[i]));
            chk("R2 low sec", 64'(out_sec[5:0]), 64'({V_W1[i][3:0], V_W0[i][31:30]}));
            @(negedge clk);
            chk("R6 single pulse", 64'(out_valid), 64'd0);
        end

        // R9 / R7: inputs move with no strobe, result stays
        capture(32'h4000_0005, 32'h2, 48'h5000);
        live_sec = 48'hFFFF_0000_0020; cap_word0 = 32'hFFFF_FFFF; cap_word1 = 32'hF;
        repeat (3) @(negedge clk);
        chk("R9 sec held", 64'(out_sec), 64'h5009);
        chk("R7 ns held", 64'(out_ns), 64'h5);
        chk("R7 no valid", 64'(out_valid), 64'd0);

        // R6 back-to-back strobes
        cap_word0 = 32'h0000_0007; cap_word1 = 32'h1; live_sec = 48'h100; cap_valid = 1'b1;
        @(negedge clk);
        chk("R6 first", 64'(out_valid), 64'd1);
        chk("R3 first sec", 64'(out_sec), 64'h104);
        cap_word0 = 32'h8000_0009; cap_word1 = 32'hC; live_sec = 48'h105;
        @(negedge clk);
        cap_valid = 1'b0;
        chk("R6 second", 64'(out_valid), 64'd1);
        chk("R4 second sec", 64'(out_sec), 64'hF2);
        chk("R1 second ns", 64'(out_ns), 64'h9);
        @(negedge clk);
        chk("R6 drained", 64'(out_valid), 64'd0);

        // R8 reset after activity
        capture(32'h0000_0001, 32'h1, 48'h40);
        rst_n = 1'b0;
        @(negedge clk);
        chk("R8 re-reset valid", 64'(out_valid), 64'd0);
        chk("R8 re-reset sec", 64'(out_sec), 64'd0);

        done = 1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog actual running expected finished");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

endmodule